// File: doc/BRIEF.md
# Debug Mailbox Channel

This block is a pair of one-word mailboxes that let a processor core and an external debugger exchange data words. Each mailbox moves data one way only. The inbound mailbox is loaded by the debugger and drained by the core. The outbound mailbox is loaded by the core and drained by the debugger. Each mailbox has a full flag. Both flags sit at fixed bits of one status word, and either side can read that word.

Both sides work by polling. A side reads the status word and then does its data access in the next cycle, with no delay or flush between the two. The debugger side is a small register window that never stalls. A write that would overwrite an unread inbound word is dropped without notice. A read of an empty outbound mailbox has no effect and returns zero.

The block has no back-pressure and no handshake. Every access completes in the cycle it is presented. The full flags take the place of a ready signal. Read data is combinational in the cycle of the access. Flag and word changes take effect at the clock edge that ends that cycle.

Top module: `dbg_mbox_chan`

## Requirements
- R1: After reset both full flags are 0 and both stored words are 0, so every status read returns 32'h0.
- R2: A debugger write to the inbound data register (address 1) while the inbound flag is 0 stores the write data and sets the inbound flag to 1.
- R3: A debugger write to address 1 while the inbound flag is 1 is dropped: the flag stays 1 and the core later reads the earlier word.
- R4: A core data read while the inbound flag is 1 returns the stored word and clears the flag. A core data read while the flag is 0 returns 32'h0 and leaves both flags unchanged.
- R5: A core write while the outbound flag is 0 stores the word and sets the outbound flag. A core write while the flag is 1 is dropped, and the debugger later reads the earlier word.
- R6: A debugger read of the outbound data register (address 2) while the outbound flag is 1 returns the word and clears the flag. The same read while the flag is 0 returns 32'h0 and changes no flag.
- R7: The status word has the inbound flag at bit 30 and the outbound flag at bit 29. All other bits are 0. The core reads it with core_stat_rd. The debugger reads it at address 0. Debugger reads of address 1 or 3 return 0, and debugger writes to addresses 0, 2 and 3 have no effect. core_rdata is 0 in any cycle without a core read strobe, and dbg_rdata is 0 in any cycle without a debugger read.
- R8: A status read in one cycle, followed directly by a data access in the next cycle, sees flags that agree with the result of that access.
- R9: A load and a drain of the same mailbox in one cycle act as the load followed by the drain. If the mailbox was empty, the reader gets the new word in that cycle and the flag ends at 0. If it was full, the load is dropped, the reader gets the old word and the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_stat_rd | input | 1 | Core status read strobe |
| core_rd | input | 1 | Core inbound data read strobe (takes priority over the status read) |
| core_rdata | output | 32 | Core read data, valid in the strobe cycle |
| core_wr | input | 1 | Core outbound data write strobe |
| core_wdata | input | 32 | Core write data |
| dbg_sel | input | 1 | Debugger access valid this cycle |
| dbg_wr | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | 2 | Register: 0 status, 1 inbound data, 2 outbound data, 3 reserved |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data, valid in the access cycle |

## Verification
A flag held in the wrong state appears at the ports the next time either side reads status. It also shows up in the very next data access: either a word that should have been dropped is returned, or a word that should have been returned reads as zero. A stored word that was corrupted or overwritten shows up only when its mailbox is drained. For that reason, every drain result is compared against the word the requirements say must survive. A wrong result from a same-cycle load and drain shows up at once in that cycle's read data, and again in the following status read.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned CH_IN     = 0;
  localparam int unsigned CH_OUT    = 1;
  localparam int unsigned DBG_ADR_W = 2;

  typedef enum logic [DBG_ADR_W-1:0] {
    REG_STAT = 2'd0,
    REG_IN   = 2'd1,
    REG_OUT  = 2'd2,
    REG_RSVD = 2'd3
  } dbg_reg_e;
endpackage

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drain_req,
  output logic              full,
  output logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] drain_data
);
  logic load_ok;
  logic full_d;

  // A load is accepted only into an empty slot; a drain after it empties it.
  assign load_ok = load_req & ~full;
  assign full_d  = (full | load_ok) & ~drain_req;

  // Drain view: stored word, or the word being loaded this cycle, else zero.
  always_comb begin
    if (full)         drain_data = word;
    else if (load_ok) drain_data = load_data;
    else              drain_data = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      full <= full_d;
      if (load_ok) word <= load_data;
    end
  end
endmodule

// File: rtl/mbox_status.sv
module mbox_status #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IN_BIT  = 30,
  parameter int unsigned OUT_BIT = 29
) (
  input  logic              in_full,
  input  logic              out_full,
  output logic [DATA_W-1:0] status
);
  always_comb begin
    status          = '0;
    status[IN_BIT]  = in_full;
    status[OUT_BIT] = out_full;
  end
endmodule

// File: rtl/mbox_dbg_port.sv
module mbox_dbg_port
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 dbg_sel,
  input  logic                 dbg_wr,
  input  logic [DBG_ADR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0]    status,
  input  logic [DATA_W-1:0]    out_drain_data,
  output logic                 in_load,
  output logic                 out_drain,
  output logic [DATA_W-1:0]    dbg_rdata
);
  logic rd_acc;
  logic wr_acc;

  assign rd_acc    = dbg_sel & ~dbg_wr;
  assign wr_acc    = dbg_sel & dbg_wr;
  assign in_load   = wr_acc & (dbg_addr == REG_IN);
  assign out_drain = rd_acc & (dbg_addr == REG_OUT);

  always_comb begin
    dbg_rdata = '0;
    if (rd_acc) begin
      unique case (dbg_addr)
        REG_STAT: dbg_rdata = status;
        REG_OUT:  dbg_rdata = out_drain_data;
        default:  dbg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_core_port.sv
module mbox_core_port #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              core_stat_rd,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] in_drain_data,
  output logic              in_drain,
  output logic              out_load,
  output logic [DATA_W-1:0] core_rdata
);
  assign in_drain = core_rd;
  assign out_load = core_wr;

  always_comb begin
    if (core_rd)           core_rdata = in_drain_data;
    else if (core_stat_rd) core_rdata = status;
    else                   core_rdata = '0;
  end
endmodule

// File: rtl/dbg_mbox_chan.sv
module dbg_mbox_chan
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IN_BIT  = 30,
  parameter int unsigned OUT_BIT = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_stat_rd,
  input  logic                 core_rd,
  output logic [DATA_W-1:0]    core_rdata,
  input  logic                 core_wr,
  input  logic [DATA_W-1:0]    core_wdata,
  input  logic                 dbg_sel,
  input  logic                 dbg_wr,
  input  logic [DBG_ADR_W-1:0] dbg_addr,
  input  logic [DATA_W-1:0]    dbg_wdata,
  output logic [DATA_W-1:0]    dbg_rdata
);
  logic [NUM_CH-1:0] load_w;
  logic [NUM_CH-1:0] drain_w;
  logic [NUM_CH-1:0] full_w;
  logic [DATA_W-1:0] load_data_w  [NUM_CH];
  logic [DATA_W-1:0] word_w       [NUM_CH];
  logic [DATA_W-1:0] drain_data_w [NUM_CH];
  logic [DATA_W-1:0] status_w;

  logic in_load, in_drain, out_load, out_drain;

  assign load_w[CH_IN]       = in_load;
  assign drain_w[CH_IN]      = in_drain;
  assign load_data_w[CH_IN]  = dbg_wdata;
  assign load_w[CH_OUT]      = out_load;
  assign drain_w[CH_OUT]     = out_drain;
  assign load_data_w[CH_OUT] = core_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    mbox_slot #(.DATA_W(DATA_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_req   (load_w[g]),
      .load_data  (load_data_w[g]),
      .drain_req  (drain_w[g]),
      .full       (full_w[g]),
      .word       (word_w[g]),
      .drain_data (drain_data_w[g])
    );
  end

  mbox_status #(.DATA_W(DATA_W), .IN_BIT(IN_BIT), .OUT_BIT(OUT_BIT)) u_status (
    .in_full  (full_w[CH_IN]),
    .out_full (full_w[CH_OUT]),
    .status   (status_w)
  );

  mbox_dbg_port #(.DATA_W(DATA_W)) u_dbg (
    .dbg_sel        (dbg_sel),
    .dbg_wr         (dbg_wr),
    .dbg_addr       (dbg_addr),
    .status         (status_w),
    .out_drain_data (drain_data_w[CH_OUT]),
    .in_load        (in_load),
    .out_drain      (out_drain),
    .dbg_rdata      (dbg_rdata)
  );

  mbox_core_port #(.DATA_W(DATA_W)) u_core (
    .core_stat_rd  (core_stat_rd),
    .core_rd       (core_rd),
    .core_wr       (core_wr),
    .status        (status_w),
    .in_drain_data (drain_data_w[CH_IN]),
    .in_drain      (in_drain),
    .out_load      (out_load),
    .core_rdata    (core_rdata)
  );
endmodule

// File: rtl/dbg_mbox_chan_chk.sv
module dbg_mbox_chan_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IN_BIT  = 30,
  parameter int unsigned OUT_BIT = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_stat_rd,
  input logic              core_rd,
  input logic              core_wr,
  input logic [DATA_W-1:0] core_rdata,
  input logic              dbg_sel,
  input logic              dbg_wr,
  input logic [1:0]        dbg_addr,
  input logic [DATA_W-1:0] dbg_wdata,
  input logic [DATA_W-1:0] dbg_rdata,
  input logic              in_full,
  input logic              out_full,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] out_word
);
  logic d_in_wr, d_out_rd;
  assign d_in_wr  = dbg_sel & dbg_wr & (dbg_addr == 2'd1);
  assign d_out_rd = dbg_sel & ~dbg_wr & (dbg_addr == 2'd2);

  p_in_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_in_wr && !in_full && !core_rd) |=> in_full);

  p_in_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && !core_rd) |=> (in_full && in_word == $past(in_word)));

  p_in_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd |=> !in_full);

  p_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && in_full) |-> core_rdata == in_word);

  p_out_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && !out_full && !d_out_rd) |=> out_full);

  p_out_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && out_full) |=> out_word == $past(out_word));

  p_out_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d_out_rd |=> !out_full);

  p_out_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_out_rd && !out_full && !core_wr) |-> dbg_rdata == '0);

  p_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stat_rd && !core_rd) |->
      (core_rdata[IN_BIT] == in_full && core_rdata[OUT_BIT] == out_full &&
       $countones(core_rdata) == ($countones(in_full) + $countones(out_full))));

  p_same_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_in_wr && core_rd && !in_full) |-> core_rdata == dbg_wdata);
endmodule

bind dbg_mbox_chan dbg_mbox_chan_chk #(
  .DATA_W(DATA_W), .IN_BIT(IN_BIT), .OUT_BIT(OUT_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_stat_rd (core_stat_rd),
  .core_rd      (core_rd),
  .core_wr      (core_wr),
  .core_rdata   (core_rdata),
  .dbg_sel      (dbg_sel),
  .dbg_wr       (dbg_wr),
  .dbg_addr     (dbg_addr),
  .dbg_wdata    (dbg_wdata),
  .dbg_rdata    (dbg_rdata),
  .in_full      (full_w[0]),
  .out_full     (full_w[1]),
  .in_word      (word_w[0]),
  .out_word     (word_w[1])
);

// File: tb/tb_dbg_mbox_chan.sv
module tb_dbg_mbox_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_stat_rd = 1'b0, core_rd = 1'b0, core_wr = 1'b0;
  logic [31:0] core_wdata = '0, core_rdata;
  logic        dbg_sel = 1'b0, dbg_wr = 1'b0;
  logic [1:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;

  int n_run = 0, n_fail = 0, seq = 0;
  bit done = 1'b0;

  // Requirement-level model
  bit          m_in_full = 0, m_out_full = 0;
  logic [31:0] m_in_word = '0, m_out_word = '0;

  dbg_mbox_chan dut (
    .clk(clk), .rst_n(rst_n),
    .core_stat_rd(core_stat_rd), .core_rd(core_rd), .core_rdata(core_rdata),
    .core_wr(core_wr), .core_wdata(core_wdata),
    .dbg_sel(dbg_sel), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] stat_word();
    return (32'(m_in_full) << 30) | (32'(m_out_full) << 29);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // dop: 0 none, 1 write in, 2 read out, 3 read status, 4 write reserved, 5 read in-addr
  // cop: 0 none, 1 status, 2 data read, 3 data write
  task automatic step(int dop, int cop, string tag,
                      logic [31:0] dd, logic [31:0] cd);
    logic [31:0] exp_d, exp_c;
    bit in_set, out_set;
    @(negedge clk);
    dbg_sel   = (dop != 0);
    dbg_wr    = (dop == 1 || dop == 4);
    dbg_addr  = (dop == 1 || dop == 5) ? 2'd1 : (dop == 2) ? 2'd2 :
                (dop == 4) ? 2'd3 : 2'd0;
    dbg_wdata = dd;
    core_stat_rd = (cop == 1);
    core_rd      = (cop == 2);
    core_wr      = (cop == 3);
    core_wdata   = cd;
    #1;
    in_set  = (dop == 1) && !m_in_full;
    out_set = (cop == 3) && !m_out_full;
    exp_d = '0;
    if (dop == 2) exp_d = m_out_full ? m_out_word : (out_set ? cd : 32'h0);
    if (dop == 3) exp_d = stat_word();
    exp_c = '0;
    if (cop == 1) exp_c = stat_word();
    if (cop == 2) exp_c = m_in_full ? m_in_word : (in_set ? dd : 32'h0);
    chk(tag != "" ? tag : (dop == 2 ? (out_set ? "R9" : "R6") : "R7"), dbg_rdata, exp_d);
    chk(tag != "" ? tag : (cop == 2 ? (in_set ? "R9" : "R4") : "R7"), core_rdata, exp_c);
    if (in_set) m_in_word = dd;
    m_in_full = (m_in_full || in_set) && !(cop == 2);
    if (out_set) m_out_word = cd;
    m_out_full = (m_out_full || out_set) && !(dop == 2);
  endtask

  task automatic idle();
    @(negedge clk);
    dbg_sel = 0; dbg_wr = 0; core_stat_rd = 0; core_rd = 0; core_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen from both sides, and empty drains return zero
    step(3, 1, "R1", '0, '0);
    step(2, 2, "R1", '0, '0);

    // R3: second inbound write dropped; first word survives
    step(1, 0, "R2", 32'hCAFE_0001, '0);
    step(1, 0, "R3", 32'hDEAD_0002, '0);
    step(3, 1, "R3", '0, '0);
    step(0, 2, "R3", '0, '0);
    // R5: second outbound write dropped
    step(0, 3, "R5", '0, 32'h1234_5678);
    step(0, 3, "R5", '0, 32'h8765_4321);
    step(2, 0, "R5", '0, '0);
    // R8: status poll then data access back to back
    step(1, 0, "R8", 32'h0BAD_F00D, '0);
    step(0, 1, "R8", '0, '0);
    step(0, 2, "R8", '0, '0);
    step(0, 1, "R8", '0, '0);
    // R9: same-cycle load and drain on each mailbox, empty and full
    step(1, 2, "R9", 32'h5555_AAAA, '0);
    step(1, 0, "R9", 32'h1111_2222, '0);
    step(1, 2, "R9", 32'h3333_4444, '0);
    step(2, 3, "R9", '0, 32'h7777_8888);
    step(3, 1, "R9", '0, '0);

    // Near-exhaustive sweep: every start state x debugger op x core op
    for (int s = 0; s < 4; s++) begin
      for (int dop = 0; dop < 6; dop++) begin
        for (int cop = 0; cop < 4; cop++) begin
          string t;
          seq++;
          step(2, 2, "", '0, '0);
          if (s[1]) step(1, 0, "R2", 32'h1000_0000 + seq * 32'h0001_0203, '0);
          if (s[0]) step(0, 3, "R5", '0, 32'h2000_0000 ^ (seq * 32'h0301_0001));
          step(dop, cop, "", 32'hA000_0000 + seq * 32'h0000_1111,
               32'h5000_0000 + seq * 32'h0101_0000);
          t = (dop == 1) ? (s[1] ? "R3" : "R2") : (cop == 3) ? "R5" :
              (dop == 2) ? "R6" : (cop == 2) ? "R4" : "R7";
          step(3, 1, t, '0, '0);
          step(2, 2, "", '0, '0);
        end
      end
    end
    idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule